// File: doc/BRIEF.md
# Clock Source Selection Controller

This block turns two small configuration registers into the clock-enable pulses that drive a system's synchronous logic. All oscillators reach it as single-cycle tick inputs in one reference clock domain. From the register fields the block picks one of five sources: the main oscillator, the fast internal oscillator, that oscillator divided by four, the slow internal oscillator, or the external real-time oscillator. It then routes either that source or the PLL output tick onto the system enable. It also derives a PWM enable and an ADC enable by synchronous division, and flags an ADC that is switched on while the system clock runs from a slow setting.

Software writes a primary register and an extended register through a single write port. The extended register holds a use bit. While that bit is set, the extended source and bypass fields replace the primary ones, and the wider source field allows the real-time oscillator. All outputs are enable pulses or status levels; no clock is gated here.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the primary register reads 0x04 and the extended register reads 0x08. `src_code` is 0, `pll_used`, `sys_ce` and `adc_err` are 0 while no tick arrives, and the PWM divider is off.
- R2: Primary layout: bits [1:0] source, bit 2 bypass, bits [5:3] PWM code, bit 6 PWM divider enable, bit 7 stored only. Source codes are 0 main, 1 fast internal, 2 fast internal divided by four, 3 slow internal. In bypass, `sys_ce` equals the selected tick input in the same cycle.
- R3: Extended layout: bits [2:0] source, bit 3 bypass, bit 7 use. While bit 7 is set, the extended source and bypass govern. Writing the extended register with bit 7 clear hands control back to the primary fields from the cycle after the write.
- R4: The extended source code 7 selects `tick_rtc`. Extended codes 4, 5 and 6 produce no system enable.
- R5: The PLL path is taken only when the effective bypass is 0 and the effective source is the main oscillator. Then `pll_used` is 1 and `sys_ce` follows `tick_pll`. With any other source, bypass is forced and `pll_used` is 0.
- R6: With source code 2, `sys_ce` pulses on every fourth `tick_int`, the first on the fourth tick.
- R7: With the PWM enable bit clear, `pwm_ce` equals `sys_ce`. With it set, `pwm_ce` pulses on every Nth `sys_ce`. N is 2, 4, 8, 16 or 32 for codes 0 to 4, and 64 for codes 5, 6 and 7.
- R8: While `pll_used` is 1 and `adc_en` is 1, `adc_ce` pulses on every ADC_DIV-th `tick_pll` (default 25). Otherwise `adc_ce` is 0.
- R9: `adc_err` is 1 exactly while `adc_en` is 1 and `pll_used` is 0.
- R10: When the effective source or bypass changes, every divider restarts from zero. The PWM divider also restarts when its code or enable bit changes. Divided pulses are suppressed in the cycle in which the change is seen, and the first divided pulse comes a full period later.
- R11: `rd_data` returns the last value written to the register chosen by `rd_sel` (0 primary, 1 extended). Writes use the same selection on `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 primary, 1 extended |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 primary, 1 extended |
| rd_data | output | 8 | Read data |
| tick_main | input | 1 | Main oscillator tick |
| tick_int | input | 1 | Fast internal oscillator tick |
| tick_lf | input | 1 | Slow internal oscillator tick |
| tick_rtc | input | 1 | Real-time oscillator tick |
| tick_pll | input | 1 | PLL output tick |
| adc_en | input | 1 | ADC is switched on |
| sys_ce | output | 1 | System clock enable |
| pwm_ce | output | 1 | PWM clock enable |
| adc_ce | output | 1 | ADC clock enable |
| src_code | output | 3 | Effective source code |
| pll_used | output | 1 | PLL path selected |
| adc_err | output | 1 | ADC on while clock setting too slow |

## Verification
A wrong decode of the registers shows up at once. In the first cycle after a write, `src_code` and `pll_used` disagree with the written fields, and `sys_ce` follows the wrong tick input on the very next tick. A divider counter that was not restarted cannot be seen until the divided pulse comes. It then arrives early, before the full 4, N or ADC_DIV ticks have passed. So the bench sets the counters part-way before each switch and then counts the ticks up to the first pulse.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;

    localparam int REG_W   = 8;
    localparam int SRC_W   = 3;
    localparam int PWM_W   = 7;   // holds divide ratio up to 64

    // primary register bit positions
    localparam int P_SRC_LSB = 0;
    localparam int P_BYP     = 2;
    localparam int P_PWM_LSB = 3;
    localparam int P_PWM_EN  = 6;

    // extended register bit positions
    localparam int E_SRC_LSB = 0;
    localparam int E_BYP     = 3;
    localparam int E_USE     = 7;

    localparam logic [REG_W-1:0] PRIM_RST = 8'h04;
    localparam logic [REG_W-1:0] EXT_RST  = 8'h08;

    localparam logic [SRC_W-1:0] SRC_MAIN = 3'd0;
    localparam logic [SRC_W-1:0] SRC_INT  = 3'd1;
    localparam logic [SRC_W-1:0] SRC_INT4 = 3'd2;
    localparam logic [SRC_W-1:0] SRC_LF   = 3'd3;
    localparam logic [SRC_W-1:0] SRC_RTC  = 3'd7;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             bypass;
        logic [2:0]       pwm_code;
        logic             pwm_en;
    } cfg_t;

    // merge the two registers: extended fields win while its use bit is set
    function automatic cfg_t merge_cfg(logic [REG_W-1:0] prim, logic [REG_W-1:0] ext);
        cfg_t c;
        c.pwm_code = prim[P_PWM_LSB +: 3];
        c.pwm_en   = prim[P_PWM_EN];
        if (ext[E_USE]) begin
            c.src    = ext[E_SRC_LSB +: SRC_W];
            c.bypass = ext[E_BYP];
        end else begin
            c.src    = {1'b0, prim[P_SRC_LSB +: 2]};
            c.bypass = prim[P_BYP];
        end
        return c;
    endfunction

    function automatic logic [PWM_W-1:0] pwm_ratio(logic [2:0] code);
        logic [PWM_W-1:0] r;
        if (code >= 3'd5) r = 7'd64;
        else              r = 7'd2 << code;
        return r;
    endfunction

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import clk_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output cfg_t             cfg
);
    logic [REG_W-1:0] prim_q;
    logic [REG_W-1:0] ext_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= PRIM_RST;
            ext_q  <= EXT_RST;
        end else if (wr_en) begin
            if (wr_sel) ext_q  <= wr_data;
            else        prim_q <= wr_data;
        end
    end

    assign rd_data = rd_sel ? ext_q : prim_q;
    assign cfg     = merge_cfg(prim_q, ext_q);

    assert_rd_tracks_write_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (prim_q == $past(wr_data)));

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             pulse
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q >= ratio - 1'b1);
    assign pulse  = tick & at_end & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt_q <= '0;
        else if (tick)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end

    assert_pulse_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        pulse |-> tick);

    assert_no_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pulse);

endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int ADC_DIV = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             tick_main,
    input  logic             tick_int,
    input  logic             tick_lf,
    input  logic             tick_rtc,
    input  logic             tick_pll,
    input  logic             adc_en,
    output logic             sys_ce,
    output logic             pwm_ce,
    output logic             adc_ce,
    output logic [SRC_W-1:0] src_code,
    output logic             pll_used,
    output logic             adc_err
);
    localparam int ADC_W = $clog2(ADC_DIV + 1);
    localparam int SEL_W = SRC_W + 1;

    cfg_t             cfg;
    logic             eff_byp;
    logic [SEL_W-1:0] sel_now, sel_q;
    logic [3:0]       pwm_now, pwm_q;
    logic             src_chg, pwm_chg;
    logic             int4_pulse, pwm_pulse, adc_pulse;
    logic             src_tick;

    cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    // only the main oscillator may feed the PLL
    assign eff_byp  = cfg.bypass | (cfg.src != SRC_MAIN);
    assign pll_used = ~eff_byp;
    assign src_code = cfg.src;

    assign sel_now = {cfg.src, eff_byp};
    assign pwm_now = {cfg.pwm_en, cfg.pwm_code};
    assign src_chg = (sel_now != sel_q);
    assign pwm_chg = (pwm_now != pwm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= {SRC_MAIN, 1'b1};
            pwm_q <= {PRIM_RST[P_PWM_EN], PRIM_RST[P_PWM_LSB +: 3]};
        end else begin
            sel_q <= sel_now;
            pwm_q <= pwm_now;
        end
    end

    tick_divider #(.CNT_W(3)) u_div_int4 (
        .clk   (clk),
        .rst   (rst),
        .clr   (src_chg),
        .tick  (tick_int),
        .ratio (3'd4),
        .pulse (int4_pulse)
    );

    always_comb begin
        case (cfg.src)
            SRC_MAIN: src_tick = tick_main;
            SRC_INT:  src_tick = tick_int;
            SRC_INT4: src_tick = int4_pulse;
            SRC_LF:   src_tick = tick_lf;
            SRC_RTC:  src_tick = tick_rtc;
            default:  src_tick = 1'b0;
        endcase
    end

    assign sys_ce = pll_used ? tick_pll : src_tick;

    tick_divider #(.CNT_W(PWM_W)) u_div_pwm (
        .clk   (clk),
        .rst   (rst),
        .clr   (src_chg | pwm_chg),
        .tick  (sys_ce),
        .ratio (pwm_ratio(cfg.pwm_code)),
        .pulse (pwm_pulse)
    );

    assign pwm_ce = cfg.pwm_en ? pwm_pulse : sys_ce;

    tick_divider #(.CNT_W(ADC_W)) u_div_adc (
        .clk   (clk),
        .rst   (rst),
        .clr   (src_chg),
        .tick  (tick_pll & pll_used),
        .ratio (ADC_W'(ADC_DIV)),
        .pulse (adc_pulse)
    );

    assign adc_ce  = adc_en & adc_pulse;
    assign adc_err = adc_en & ~pll_used;

    assert_pll_tick_R5: assert property (@(posedge clk) disable iff (rst)
        (sys_ce && pll_used) |-> tick_pll);

    assert_reserved_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (src_code inside {3'd4, 3'd5, 3'd6}) |-> !sys_ce);

    assert_ext_release_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !wr_data[E_USE]) |=> (src_code[2] == 1'b0));

    assert_adc_needs_pll_R8: assert property (@(posedge clk) disable iff (rst)
        adc_ce |-> (pll_used && tick_pll));

    assert_err_blocks_adc_R9: assert property (@(posedge clk) disable iff (rst)
        adc_err |-> !adc_ce);

endmodule

// File: tb/clk_src_ctrl_bench.sv
module clk_src_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [4:0] ticks = '0;   // {pll, rtc, lf, int, main}
    logic       adc_en = 1'b0;
    logic       sys_ce, pwm_ce, adc_ce, pll_used, adc_err;
    logic [2:0] src_code;
    int         n_chk = 0, n_fail = 0, cyc = 0;

    always #2.5 clk = ~clk;

    clk_src_ctrl u_clk_src_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .tick_main(ticks[0]), .tick_int(ticks[1]), .tick_lf(ticks[2]),
        .tick_rtc(ticks[3]), .tick_pll(ticks[4]), .adc_en(adc_en),
        .sys_ce(sys_ce), .pwm_ce(pwm_ce), .adc_ce(adc_ce), .src_code(src_code),
        .pll_used(pll_used), .adc_err(adc_err)
    );

    // {prim, ext, ticks, exp_sys, exp_pll, exp_src}
    localparam logic [25:0] VEC [0:12] = '{
        {8'h04, 8'h08, 5'h01, 1'b1, 1'b0, 3'd0},   // R2 main
        {8'h04, 8'h08, 5'h1E, 1'b0, 1'b0, 3'd0},   // R2 main, others ignored
        {8'h0F, 8'h08, 5'h04, 1'b1, 1'b0, 3'd3},   // R2 slow internal
        {8'h0F, 8'h08, 5'h1B, 1'b0, 1'b0, 3'd3},   // R2
        {8'h00, 8'h08, 5'h10, 1'b1, 1'b1, 3'd0},   // R5 PLL path
        {8'h00, 8'h08, 5'h0F, 1'b0, 1'b1, 3'd0},   // R5
        {8'h01, 8'h08, 5'h02, 1'b1, 1'b0, 3'd1},   // R5 forced bypass
        {8'h01, 8'h08, 5'h10, 1'b0, 1'b0, 3'd1},   // R5
        {8'h04, 8'h87, 5'h08, 1'b1, 1'b0, 3'd7},   // R4 real-time source
        {8'h04, 8'h87, 5'h17, 1'b0, 1'b0, 3'd7},   // R4
        {8'h0C, 8'h80, 5'h10, 1'b1, 1'b1, 3'd0},   // R3 extended wins
        {8'h04, 8'h85, 5'h1F, 1'b0, 1'b0, 3'd5},   // R4 reserved code
        {8'h07, 8'h08, 5'h04, 1'b1, 1'b0, 3'd3}    // R3 extended unused
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // apply n ticks; which: 0 sys, 1 pwm, 2 adc; report first pulse index and count
    task automatic run(input logic [4:0] t, input int n, input int which,
                       output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 0; i < n; i++) begin
            logic o;
            @(negedge clk);
            ticks = t; #1;
            o = (which == 0) ? sys_ce : (which == 1) ? pwm_ce : adc_ce;
            if (o) begin
                if (first < 0) first = i;
                cnt++;
            end
            @(posedge clk); #1;
            ticks = '0;
        end
    endtask

    initial begin
        int f, c;
        idle(3);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        rd_sel = 1'b0; #1; chk("R1 prim", rd_data, 8'h04);
        rd_sel = 1'b1; #1; chk("R1 ext", rd_data, 8'h08);
        chk("R1 src", src_code, 0);
        chk("R1 pll", pll_used, 0);
        chk("R1 sys", sys_ce, 0);
        chk("R1 err", adc_err, 0);

        // table walk: R2 R3 R4 R5
        for (int k = 0; k < 13; k++) begin
            logic [25:0] v;
            v = VEC[k];
            wr(1'b0, v[25:18]);
            wr(1'b1, v[17:10]);
            idle(2);
            @(negedge clk);
            ticks = v[9:5]; #1;
            chk($sformatf("R2-5 vec%0d sys", k), sys_ce, v[4]);
            chk($sformatf("R5 vec%0d pll", k), pll_used, v[3]);
            chk($sformatf("R3 vec%0d src", k), src_code, v[2:0]);
            @(posedge clk); #1;
            ticks = '0;
        end

        // R3 release on next cycle
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h87);
        chk("R3 ext active", src_code, 7);
        wr(1'b1, 8'h07);
        chk("R3 primary restored", src_code, 1);

        // R11 readback
        wr(1'b0, 8'hB9);
        wr(1'b1, 8'h3C);
        rd_sel = 1'b0; #1; chk("R11 prim", rd_data, 8'hB9);
        rd_sel = 1'b1; #1; chk("R11 ext", rd_data, 8'h3C);
        wr(1'b1, 8'h08);

        // R6 divide by four
        wr(1'b0, 8'h06); idle(2);
        run(5'h02, 8, 0, f, c);
        chk("R6 first", f, 3);
        chk("R6 count", c, 2);

        // R10 restart after source change
        run(5'h02, 2, 0, f, c);
        wr(1'b0, 8'h07); idle(2);
        wr(1'b0, 8'h06); idle(2);
        run(5'h02, 4, 0, f, c);
        chk("R10 first after switch", f, 3);
        chk("R10 count", c, 1);

        // R7 PWM passthrough
        wr(1'b0, 8'h04); idle(2);
        run(5'h01, 3, 1, f, c);
        chk("R7 passthrough", c, 3);
        // R7 divided ratios: codes 0, 2, 7
        wr(1'b0, 8'h44); idle(2);
        run(5'h01, 4, 1, f, c);
        chk("R7 div2 first", f, 1); chk("R7 div2 count", c, 2);
        wr(1'b0, 8'h54); idle(2);
        run(5'h01, 16, 1, f, c);
        chk("R7 div8 first", f, 7); chk("R7 div8 count", c, 2);
        wr(1'b0, 8'h7C); idle(2);
        run(5'h01, 128, 1, f, c);
        chk("R7 div64 first", f, 63); chk("R7 div64 count", c, 2);

        // R9 error flag
        adc_en = 1'b1;
        wr(1'b0, 8'h04); idle(1);
        chk("R9 err slow clock", adc_err, 1);
        // R8 ADC divide on PLL
        wr(1'b0, 8'h00); idle(2);
        chk("R9 err clear on PLL", adc_err, 0);
        run(5'h10, 50, 2, f, c);
        chk("R8 first", f, 24); chk("R8 count", c, 2);
        adc_en = 1'b0;
        run(5'h10, 30, 2, f, c);
        chk("R8 adc off", c, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule